// File: doc/BRIEF.md
# Maskable Event Flag and Interrupt Register Set

This block is the software-facing event and interrupt front end of a serial highway controller. Twelve sticky flags capture single-cycle event pulses raised by the rest of the controller. A twelve-bit mask selects which flags may interrupt, and a global enable gates the whole interrupt. Software reaches everything through a small word-addressed register port. Writes carry command bits that pick a clear-all, a selective clear or a selective set. The global enable drops by itself when software writes the interrupt vector back as an acknowledge.

A summary condition word gathers the most useful state in one read: the last X and Q responses, the enable, a summary of any unmasked pending flag, copies of four key flags and two mode inputs. It also carries a booking bit, a read-to-claim semaphore. The first reader that finds it clear claims it, and a write releases it. This lets several masters share the controller. A write to a dedicated address performs a programmed reset of all state.

Top module: `hwy_irq_regs`

## Requirements
- R1: After reset, all flags, the mask, the enable, the vector and the booking bit are zero and `irq` is low.
- R2: An event pulse on `evt_pulse[i]` sets flag i, and the flag stays set until it is cleared. Reading address 3 returns the flags in bits 11:0 and zero above. Flag index order is: 0 transmit done, 1 command complete, 2 demand received, 3 sync lost, 4 timeout, 5 address not recognised, 6 Q was 0, 7 X was 0, 8 error, 9 delayed error, 10 linear parity error, 11 transverse parity error.
- R3: A write to address 3 with bit 12 = 0 clears every flag. With bit 12 = 1, it clears only the flags selected in bits 11:0.
- R4: When an event pulse and a clear of the same flag fall in the same cycle, the flag ends up set.
- R5: A write to address 1 updates the mask according to its command bits. With none of bits 12..14 set, bits 11:0 are loaded. Otherwise the steps apply in this order: bit 12 clears the whole mask, bit 13 clears the mask bits selected in 11:0, and bit 14 sets the mask bits selected in 11:0. The mask reads back at address 1 in bits 11:0.
- R6: `irq` is a level that is high exactly when the enable is set and at least one flag is set with its mask bit set. It follows the register state with no further delay.
- R7: A write to address 0 with bit 4 = 1 sets the enable; bit 4 = 0 leaves it alone. Any write to address 2 clears the enable.
- R8: A write to address 2 stores bits 31:16 as the vector. Reading address 2 returns the vector in bits 31:16 and zero in bits 15:0.
- R9: A read of address 0 returns the booking bit as it was before the read, in bit 0, and leaves it set. Bit 1 reads as the complement of bit 0. A write to address 0 with bit 0 = 1 clears the booking bit.
- R10: The condition word at address 0 has this layout: bit 2 `last_x`, bit 3 `last_q`, bit 4 enable, bit 5 any flag set with its mask bit set (independent of enable), bit 6 command-complete flag, bit 7 transmit-done flag, bit 8 demand flag, bit 9 sync-lost flag, bit 10 `arb_mode`, bit 11 `byte_mode`, bits 31:12 zero.
- R11: Any write to address 4 clears the flags, mask, enable, vector and booking bit, as reset does.
- R12: Read data is registered. It appears on `bus_rdata` on the clock edge that samples `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 12 | Single-cycle event pulses, one per flag |
| last_x | input | 1 | X response of the last command |
| last_q | input | 1 | Q response of the last command |
| byte_mode | input | 1 | Byte-serial mode indicator |
| arb_mode | input | 1 | Arbitrated-bus reply mode indicator |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong flag or mask bit is visible in two ways: in the read-back word one cycle after a read is issued, and on `irq` at the next clock edge, as soon as the enable and the mask line up with it. A lost event in a clear collision shows as a zero at address 3 right after the colliding write. A stuck enable shows as `irq` staying high in the cycle after a vector acknowledge. A booking bit that fails to set or release shows on the very next condition read.

// File: rtl/hwy_irq_pkg.sv
// Shared constants for the event flag / interrupt register set.
// Assumes a 32-bit data path and a 3-bit word address.
package hwy_irq_pkg;
    localparam int NFLAG  = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int VEC_W  = 16;
    localparam int VEC_LO = DATA_W - VEC_W;

    // mask write command bits
    localparam int MCMD_CLRALL = 12;
    localparam int MCMD_CLRSEL = 13;
    localparam int MCMD_SETSEL = 14;
    // status write command bit
    localparam int SCMD_SEL    = 12;

    // condition word bit positions
    localparam int CB_BOOK  = 0;
    localparam int CB_AVAIL = 1;
    localparam int CB_X     = 2;
    localparam int CB_Q     = 3;
    localparam int CB_EN    = 4;
    localparam int CB_LAM   = 5;
    localparam int CB_CMD   = 6;
    localparam int CB_TX    = 7;
    localparam int CB_DMD   = 8;
    localparam int CB_SYNC  = 9;
    localparam int CB_ARB   = 10;
    localparam int CB_BYTE  = 11;

    // flag indices
    localparam int FL_TXDONE  = 0;
    localparam int FL_CMDDONE = 1;
    localparam int FL_DEMAND  = 2;
    localparam int FL_SYNC    = 3;
    localparam int FL_TMO     = 4;
    localparam int FL_NOADDR  = 5;
    localparam int FL_QZERO   = 6;
    localparam int FL_XZERO   = 7;
    localparam int FL_ERR     = 8;
    localparam int FL_DERR    = 9;
    localparam int FL_LPE     = 10;
    localparam int FL_TPE     = 11;

    typedef enum logic [ADDR_W-1:0] {
        RA_COND = 3'd0,
        RA_MASK = 3'd1,
        RA_VEC  = 3'd2,
        RA_STAT = 3'd3,
        RA_SRST = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/hwy_irq_flag_bank.sv
// Sticky event flags. Each bit is set by its event pulse and cleared by a
// global or selective clear; an event in the same cycle beats the clear.
// Assumes events are single-cycle pulses synchronous to clk.
module hwy_irq_flag_bank #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_all,
    input  logic         clr_sel,
    input  logic [N-1:0] sel,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;
        logic kill;
        assign kill = clr_all | (clr_sel & sel[i]);

        // one sticky flag: event sets, clear drops, event has priority
        always_ff @(posedge clk) begin
            if (!rst_n)      q <= 1'b0;
            else if (evt[i]) q <= 1'b1;
            else if (kill)   q <= 1'b0;
        end

        assign flags[i] = q;
    end
endmodule

// File: rtl/hwy_irq_mask_reg.sv
// Interrupt mask with command-coded writes: plain load, clear-all,
// selective clear and selective set, applied in that order.
// Assumes the caller qualifies wr with the mask address.
module hwy_irq_mask_reg #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         srst,
    input  logic         cmd_clr_all,
    input  logic         cmd_clr_sel,
    input  logic         cmd_set_sel,
    input  logic [N-1:0] bits,
    output logic [N-1:0] mask
);
    logic [N-1:0] nxt;
    logic         plain_load;

    assign plain_load = ~(cmd_clr_all | cmd_clr_sel | cmd_set_sel);

    // next mask value from the write command
    always_comb begin
        nxt = mask;
        if (wr) begin
            if (plain_load) begin
                nxt = bits;
            end else begin
                if (cmd_clr_all) nxt = '0;
                if (cmd_clr_sel) nxt = nxt & ~bits;
                if (cmd_set_sel) nxt = nxt | bits;
            end
        end
        if (srst) nxt = '0;
    end

    // mask storage
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= nxt;
    end
endmodule

// File: rtl/hwy_irq_ctrl.sv
// Control state: booking semaphore, global interrupt enable, vector.
// Booking sets on a condition read and releases on a write with the
// release bit; the enable self-clears on a vector write (acknowledge).
module hwy_irq_ctrl #(
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          cond_rd,
    input  logic          cond_wr,
    input  logic          rel_bit,
    input  logic          en_bit,
    input  logic          vec_wr,
    input  logic [VW-1:0] vec_in,
    output logic          booked,
    output logic          en,
    output logic [VW-1:0] vec
);
    // booking semaphore: release wins over a same-cycle read
    always_ff @(posedge clk) begin
        if (!rst_n || srst)           booked <= 1'b0;
        else if (cond_wr && rel_bit)  booked <= 1'b0;
        else if (cond_rd)             booked <= 1'b1;
    end

    // global enable: set by software, dropped by vector acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n || srst)          en <= 1'b0;
        else if (vec_wr)             en <= 1'b0;
        else if (cond_wr && en_bit)  en <= 1'b1;
    end

    // interrupt vector storage
    always_ff @(posedge clk) begin
        if (!rst_n || srst) vec <= '0;
        else if (vec_wr)    vec <= vec_in;
    end
endmodule

// File: rtl/hwy_irq_regs.sv
// Top of the event flag / mask / interrupt register set. Decodes the
// register port, assembles read data (registered) and drives the level
// interrupt. Assumes bus_wr and bus_rd are single-cycle strobes.
module hwy_irq_regs
    import hwy_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NFLAG-1:0]  evt_pulse,
    input  logic              last_x,
    input  logic              last_q,
    input  logic              byte_mode,
    input  logic              arb_mode,
    output logic              irq
);
    logic wr_cond, wr_mask, wr_vec, wr_stat, wr_srst, rd_cond;
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] mask_q;
    logic [NFLAG-1:0] pend;
    logic             irq_en_q;
    logic             booked_q;
    logic [VEC_W-1:0] vec_q;
    logic [DATA_W-1:0] cond_word;
    logic [DATA_W-1:0] rd_mux;

    // address decode
    always_comb begin
        wr_cond = bus_wr && (bus_addr == RA_COND);
        wr_mask = bus_wr && (bus_addr == RA_MASK);
        wr_vec  = bus_wr && (bus_addr == RA_VEC);
        wr_stat = bus_wr && (bus_addr == RA_STAT);
        wr_srst = bus_wr && (bus_addr == RA_SRST);
        rd_cond = bus_rd && (bus_addr == RA_COND);
    end

    hwy_irq_flag_bank #(.N(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_pulse),
        .clr_all ((wr_stat && !bus_wdata[SCMD_SEL]) || wr_srst),
        .clr_sel (wr_stat && bus_wdata[SCMD_SEL]),
        .sel     (bus_wdata[NFLAG-1:0]),
        .flags   (flags_q)
    );

    hwy_irq_mask_reg #(.N(NFLAG)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (wr_mask),
        .srst        (wr_srst),
        .cmd_clr_all (bus_wdata[MCMD_CLRALL]),
        .cmd_clr_sel (bus_wdata[MCMD_CLRSEL]),
        .cmd_set_sel (bus_wdata[MCMD_SETSEL]),
        .bits        (bus_wdata[NFLAG-1:0]),
        .mask        (mask_q)
    );

    hwy_irq_ctrl #(.VW(VEC_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (wr_srst),
        .cond_rd (rd_cond),
        .cond_wr (wr_cond),
        .rel_bit (bus_wdata[CB_BOOK]),
        .en_bit  (bus_wdata[CB_EN]),
        .vec_wr  (wr_vec),
        .vec_in  (bus_wdata[DATA_W-1:VEC_LO]),
        .booked  (booked_q),
        .en      (irq_en_q),
        .vec     (vec_q)
    );

    assign pend = flags_q & mask_q;

    // condition summary word
    always_comb begin
        cond_word           = '0;
        cond_word[CB_BOOK]  = booked_q;
        cond_word[CB_AVAIL] = ~booked_q;
        cond_word[CB_X]     = last_x;
        cond_word[CB_Q]     = last_q;
        cond_word[CB_EN]    = irq_en_q;
        cond_word[CB_LAM]   = |pend;
        cond_word[CB_CMD]   = flags_q[FL_CMDDONE];
        cond_word[CB_TX]    = flags_q[FL_TXDONE];
        cond_word[CB_DMD]   = flags_q[FL_DEMAND];
        cond_word[CB_SYNC]  = flags_q[FL_SYNC];
        cond_word[CB_ARB]   = arb_mode;
        cond_word[CB_BYTE]  = byte_mode;
    end

    // read data selection
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            RA_COND: rd_mux = cond_word;
            RA_MASK: rd_mux[NFLAG-1:0] = mask_q;
            RA_VEC:  rd_mux = {vec_q, {VEC_LO{1'b0}}};
            RA_STAT: rd_mux[NFLAG-1:0] = flags_q;
            default: rd_mux = '0;
        endcase
    end

    // registered read port, holds between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq = irq_en_q & (|pend);
endmodule

// File: rtl/hwy_irq_regs_chk.sv
// Assertion checker for hwy_irq_regs, attached by bind.
module hwy_irq_regs_chk
    import hwy_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NFLAG-1:0]  evt_pulse,
    input logic [NFLAG-1:0]  flags,
    input logic [NFLAG-1:0]  mask,
    input logic              en,
    input logic              booked,
    input logic              irq
);
    // R2: every pulsed event is held in its flag the next cycle
    p_event_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags & $past(evt_pulse)) == $past(evt_pulse)));

    // R3: a flag only falls after a status write or programmed reset
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags & $past(flags)) != '0) |->
            $past(bus_wr && (bus_addr == RA_STAT || bus_addr == RA_SRST)));

    // R5: the mask changes only on a write
    p_mask_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> $stable(mask));

    // R6: enabled unmasked event with no write in between raises irq
    p_irq_on_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && en && ((evt_pulse & mask) != '0) && !bus_wr) |-> irq);

    // R7: a vector acknowledge drops the enable and irq
    p_ack_drops_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == RA_VEC) |-> (!en && !irq));

    // R9: a condition read leaves the booking bit set
    p_read_books_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && bus_rd && !bus_wr && bus_addr == RA_COND) |-> booked);
endmodule

bind hwy_irq_regs hwy_irq_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .evt_pulse (evt_pulse),
    .flags     (flags_q),
    .mask      (mask_q),
    .en        (irq_en_q),
    .booked    (booked_q),
    .irq       (irq)
);

// File: tb/tb_hwy_irq_regs.sv
module tb_hwy_irq_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [11:0] evt_pulse;
    logic        last_x, last_q, byte_mode, arb_mode;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    hwy_irq_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .last_x(last_x), .last_q(last_q),
        .byte_mode(byte_mode), .arb_mode(arb_mode), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [11:0] v);
        @(negedge clk);
        evt_pulse = v;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'd0, irq}, 32'd0);
        rd(3'd3, d); check("R1 flags", d, 32'd0);
        rd(3'd1, d); check("R1 mask", d, 32'd0);
        rd(3'd2, d); check("R1 vector", d, 32'd0);
        rd(3'd0, d); check("R1 cond", d, 32'h0000_0802);
        wr(3'd0, 32'h1);
    endtask

    task automatic t_events();
        logic [31:0] d;
        pulse(12'h021);
        repeat (3) @(negedge clk);
        rd(3'd3, d); check("R2 sticky flags", d, 32'h021);
        pulse(12'h800);
        rd(3'd3, d); check("R2 flag 11", d, 32'h821);
        repeat (4) @(negedge clk);
        check("R12 rdata holds", bus_rdata, 32'h821);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(3'd3, 32'h0000_1001);
        rd(3'd3, d); check("R3 selective clear", d, 32'h820);
        pulse(12'h00F);
        wr(3'd3, 32'h0000_0FFF);
        rd(3'd3, d); check("R3 clear all bit12=0", d, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        @(negedge clk);
        evt_pulse = 12'h008; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0;
        @(negedge clk);
        evt_pulse = '0; bus_wr = 1'b0;
        rd(3'd3, d); check("R4 event beats clear-all", d, 32'h008);
        @(negedge clk);
        evt_pulse = 12'h008; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0000_1008;
        @(negedge clk);
        evt_pulse = '0; bus_wr = 1'b0;
        rd(3'd3, d); check("R4 event beats selective clear", d, 32'h008);
        wr(3'd3, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(3'd1, 32'h0000_0ABC); rd(3'd1, d); check("R5 load", d, 32'hABC);
        wr(3'd1, 32'h0000_200C); rd(3'd1, d); check("R5 sel clear", d, 32'hAB0);
        wr(3'd1, 32'h0000_4003); rd(3'd1, d); check("R5 sel set", d, 32'hAB3);
        wr(3'd1, 32'h0000_1000); rd(3'd1, d); check("R5 clear all", d, 32'h0);
        wr(3'd1, 32'h0000_5005); rd(3'd1, d); check("R5 clear-all then set", d, 32'h005);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(3'd1, 32'h0000_0010);
        pulse(12'h001);
        check("R6 unmasked flag no irq", {31'd0, irq}, 32'd0);
        pulse(12'h010);
        check("R6 enable off no irq", {31'd0, irq}, 32'd0);
        wr(3'd0, 32'h0000_0010);
        check("R7 enable sets irq", {31'd0, irq}, 32'd1);
        repeat (3) @(negedge clk);
        check("R6 level holds", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'h0);
        check("R7 bit4=0 keeps enable", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'h0000_1000);
        check("R6 mask cleared drops irq", {31'd0, irq}, 32'd0);
        wr(3'd1, 32'h0000_0010);
        check("R6 mask restored", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'hBEEF_1234);
        check("R7 vector ack drops irq", {31'd0, irq}, 32'd0);
        rd(3'd2, d); check("R8 vector readback", d, 32'hBEEF_0000);
        wr(3'd3, 32'h0);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_booking();
        logic [31:0] d;
        rd(3'd0, d); check("R9 first read free", d & 32'h3, 32'h2);
        rd(3'd0, d); check("R9 second read booked", d & 32'h3, 32'h1);
        wr(3'd0, 32'h1);
        rd(3'd0, d); check("R9 release", d & 32'h3, 32'h2);
        wr(3'd0, 32'h1);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        last_x = 1'b1; last_q = 1'b1; arb_mode = 1'b1; byte_mode = 1'b0;
        wr(3'd1, 32'h0000_0002);
        pulse(12'h00F);
        rd(3'd0, d); check("R10 cond layout", d, 32'h0000_07EE);
        wr(3'd0, 32'h0000_0011);
        rd(3'd0, d); check("R10 enable bit", d, 32'h0000_07FE);
        wr(3'd0, 32'h1);
        last_x = 1'b0; last_q = 1'b0; arb_mode = 1'b0; byte_mode = 1'b1;
    endtask

    task automatic t_srst();
        logic [31:0] d;
        wr(3'd1, 32'h0000_0FFF);
        wr(3'd2, 32'h1234_0000);
        wr(3'd0, 32'h0000_0010);
        pulse(12'h0F0);
        rd(3'd0, d);
        check("R11 irq before reset", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h0);
        check("R11 irq after", {31'd0, irq}, 32'd0);
        rd(3'd3, d); check("R11 flags", d, 32'h0);
        rd(3'd1, d); check("R11 mask", d, 32'h0);
        rd(3'd2, d); check("R11 vector", d, 32'h0);
        rd(3'd0, d); check("R11 cond", d, 32'h0000_0802);
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
        bus_wdata = '0; evt_pulse = '0;
        last_x = 1'b0; last_q = 1'b0; byte_mode = 1'b1; arb_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_clear();
        t_collision();
        t_mask();
        t_irq();
        t_booking();
        t_layout();
        t_srst();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule